// File: doc/BRIEF.md
# Serial Voltage-Code Command Receiver

This block sits in a voltage regulator controller and listens on a two-wire link, a serial clock and a serial data line, both driven by the processor. Both lines are brought into the system clock domain through two-flop synchronizers, and the block detects edges on them there. A frame opens with a start condition. Six address bits select one of two supply rails: the core rail or the north-bridge rail. A control bit tells a write from a read. The block answers a matched write with one acknowledge clock, and then takes in an eight-bit payload.

The payload carries a seven-bit voltage code in its low bits and a power-saving flag in its top bit. Once the last payload bit has arrived, the addressed rail's code and flag load together, and a one-cycle update strobe fires in the same cycle. A matched read raises a one-cycle read flag and changes nothing else. Frames that are unmatched, cut short or never started leave both rails as they were.

Top module: `vcmd_rx`

## Requirements
- R1: After reset, both rails hold BOOT_CODE (default 7'h40) with the power-saving flag at 0, and ack_o, rd_o and upd_o are 0.
- R2: A frame begins only on a start condition, which is the data line falling while the serial clock is high. Bits are sampled on rising serial clock edges, most significant bit first. Clocked bits with no start condition before them do nothing.
- R3: Address CORE_ADDR (default 6'h10) targets the core rail and NB_ADDR (default 6'h11) targets the north-bridge rail. Payload bits 6:0 are the voltage code and payload bit 7 is the power-saving flag.
- R4: ack_o goes high after the control-bit rising edge when the address matches and the control bit is 0 (write). It stays high through the low phase that follows and falls once the next rising edge, the acknowledge clock, has been taken in.
- R5: For an address that matches neither rail, ack_o stays 0, no update strobe fires and both rails keep their values, even though a payload follows.
- R6: A matched address with the control bit at 1 (read) raises rd_o for exactly one cycle. It gives no acknowledge and no update.
- R7: A complete matched write loads the targeted rail's code and flag in the same cycle and pulses upd_o for exactly one cycle. The other rail is left unchanged.
- R8: A start condition that arrives before all eight payload bits are in drops the pending frame, so both rails stay unchanged. A following complete frame is then received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the processor |
| sdat_i | input | 1 | Serial data from the processor |
| ack_o | output | 1 | Acknowledge for a matched write |
| rd_o | output | 1 | One-cycle flag for a matched read |
| upd_o | output | 1 | One-cycle rail update strobe |
| core_code_o | output | 7 | Core rail voltage code |
| core_psi_o | output | 1 | Core rail power-saving flag |
| nb_code_o | output | 7 | North-bridge rail voltage code |
| nb_psi_o | output | 1 | North-bridge rail power-saving flag |

## Verification
The bench sends one address that is the core address with its bits in reverse order. A receiver that shifted least significant bit first would accept that frame and corrupt the core rail. It also clocks a full valid write with no start condition before it, which a receiver that ignored the start condition would apply. A frame is cut off after four payload bits by a fresh start condition, and a design that loaded partial shift contents or failed to restart would show a changed rail or a stray strobe. Reads to both rails and an unmatched address with a payload after it check that only a matched write ever acknowledges or updates, and the all-ones and all-zero payloads check that the flag and code split at bit 7.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;
  localparam int ADDR_W    = 6;
  localparam int CODE_W    = 7;
  localparam int PAY_W     = CODE_W + 1;
  localparam int NUM_RAILS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RW,
    ST_ACK,
    ST_DATA
  } rx_state_e;
endpackage

// File: rtl/vcmd_sync.sv
module vcmd_sync #(
  parameter int  W        = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= {W{RST_VAL}};
      s2_q <= {W{RST_VAL}};
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/vcmd_frame_dec.sv
module vcmd_frame_dec
  import vcmd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CORE_ADDR = 6'h10,
  parameter logic [ADDR_W-1:0] NB_ADDR   = 6'h11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output logic              ack_o,
  output logic              rd_o,
  output logic              upd_o,
  output logic              upd_sel_o,
  output logic [CODE_W-1:0] upd_code_o,
  output logic              upd_psi_o
);
  localparam int CNT_W = $clog2(PAY_W);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PAY_W-1:0]  data_q;
  logic              sclk_d, sdat_d;
  logic              ack_q, rd_q, upd_q, sel_q;
  logic              rise, start, hit;

  assign rise  = sclk_i & ~sclk_d;
  assign start = sclk_i & sclk_d & sdat_d & ~sdat_i;
  assign hit   = (addr_q == CORE_ADDR) || (addr_q == NB_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      sclk_d  <= 1'b1;
      sdat_d  <= 1'b1;
      ack_q   <= 1'b0;
      rd_q    <= 1'b0;
      upd_q   <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      sclk_d <= sclk_i;
      sdat_d <= sdat_i;
      rd_q   <= 1'b0;
      upd_q  <= 1'b0;
      if (start) begin
        // a new start always wins and drops any pending frame
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        ack_q   <= 1'b0;
      end else if (rise) begin
        unique case (state_q)
          ST_ADDR: begin
            addr_q <= {addr_q[ADDR_W-2:0], sdat_i};
            if (cnt_q == CNT_W'(ADDR_W - 1)) begin
              state_q <= ST_RW;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RW: begin
            if (hit && !sdat_i) begin
              ack_q   <= 1'b1;
              sel_q   <= (addr_q == NB_ADDR);
              state_q <= ST_ACK;
            end else begin
              rd_q    <= hit;
              state_q <= ST_IDLE;
            end
          end
          ST_ACK: begin
            ack_q   <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end
          ST_DATA: begin
            data_q <= {data_q[PAY_W-2:0], sdat_i};
            if (cnt_q == CNT_W'(PAY_W - 1)) begin
              upd_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign ack_o      = ack_q;
  assign rd_o       = rd_q;
  assign upd_o      = upd_q;
  assign upd_sel_o  = sel_q;
  assign upd_code_o = data_q[CODE_W-1:0];
  assign upd_psi_o  = data_q[PAY_W-1];

  assert_upd_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> !upd_q);
  assert_ack_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> (!$past(sdat_i) && (addr_q == CORE_ADDR || addr_q == NB_ADDR)));
  assert_ack_no_upd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> !upd_q);
  assert_rd_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |-> (!ack_q && !upd_q));
  assert_rd_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |=> !rd_q);
endmodule

// File: rtl/vcmd_rail.sv
module vcmd_rail
  import vcmd_pkg::*;
#(
  parameter logic [CODE_W-1:0] BOOT_CODE = 7'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              psi_i,
  output logic [CODE_W-1:0] code_o,
  output logic              psi_o
);
  logic [CODE_W-1:0] code_q;
  logic              psi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= BOOT_CODE;
      psi_q  <= 1'b0;
    end else if (wr_en_i) begin
      code_q <= code_i;
      psi_q  <= psi_i;
    end
  end

  assign code_o = code_q;
  assign psi_o  = psi_q;

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(code_q) && $stable(psi_q)));
  assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (code_q == $past(code_i) && psi_q == $past(psi_i)));
endmodule

// File: rtl/vcmd_rx.sv
module vcmd_rx
  import vcmd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CORE_ADDR = 6'h10,
  parameter logic [ADDR_W-1:0] NB_ADDR   = 6'h11,
  parameter logic [CODE_W-1:0] BOOT_CODE = 7'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output logic              ack_o,
  output logic              rd_o,
  output logic              upd_o,
  output logic [CODE_W-1:0] core_code_o,
  output logic              core_psi_o,
  output logic [CODE_W-1:0] nb_code_o,
  output logic              nb_psi_o
);
  logic [1:0]           line_s;
  logic                 upd, upd_sel, upd_psi;
  logic [CODE_W-1:0]    upd_code;
  logic [NUM_RAILS-1:0] wr_en;
  logic [CODE_W-1:0]    rail_code [NUM_RAILS];
  logic [NUM_RAILS-1:0] rail_psi;

  vcmd_sync #(.W(2), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, sdat_i}),
    .q_o    (line_s)
  );

  vcmd_frame_dec #(.CORE_ADDR(CORE_ADDR), .NB_ADDR(NB_ADDR)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (line_s[1]),
    .sdat_i     (line_s[0]),
    .ack_o      (ack_o),
    .rd_o       (rd_o),
    .upd_o      (upd),
    .upd_sel_o  (upd_sel),
    .upd_code_o (upd_code),
    .upd_psi_o  (upd_psi)
  );

  // rail 0 = core, rail 1 = north bridge
  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    assign wr_en[g] = upd && (upd_sel == 1'(g));
    vcmd_rail #(.BOOT_CODE(BOOT_CODE)) u_rail (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en[g]),
      .code_i  (upd_code),
      .psi_i   (upd_psi),
      .code_o  (rail_code[g]),
      .psi_o   (rail_psi[g])
    );
  end

  assign upd_o       = upd;
  assign core_code_o = rail_code[0];
  assign core_psi_o  = rail_psi[0];
  assign nb_code_o   = rail_code[1];
  assign nb_psi_o    = rail_psi[1];

  assert_one_rail_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en));
  assert_strobe_rail_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |-> ($countones(wr_en) == 1));
endmodule

// File: tb/vcmd_rx_tb.sv
`timescale 1ns/1ps
module vcmd_rx_tb;
  localparam logic [5:0] CORE_A = 6'h10;
  localparam logic [5:0] NB_A   = 6'h11;
  localparam logic [6:0] BOOT   = 7'h40;
  localparam int H = 8;
  localparam int NV = 8;
  // {addr[14:9], rw[8], payload[7:0]}
  localparam logic [14:0] VEC [NV] = '{
    {6'h10, 1'b0, 8'h95},
    {6'h11, 1'b0, 8'h2A},
    {6'h12, 1'b0, 8'hFF},
    {6'h10, 1'b1, 8'h00},
    {6'h10, 1'b0, 8'h00},
    {6'h11, 1'b0, 8'hFF},
    {6'h02, 1'b0, 8'h33},
    {6'h11, 1'b1, 8'h12}
  };

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, sdat = 1'b1;
  logic ack, rd, upd, core_psi, nb_psi;
  logic [6:0] core_code, nb_code;
  int n_chk = 0, n_fail = 0, upd_cnt = 0, rd_cnt = 0;
  logic [6:0] m_core = BOOT, m_nb = BOOT;
  logic m_core_psi = 1'b0, m_nb_psi = 1'b0;

  always #2 clk = ~clk;

  vcmd_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdat_i(sdat),
    .ack_o(ack), .rd_o(rd), .upd_o(upd),
    .core_code_o(core_code), .core_psi_o(core_psi),
    .nb_code_o(nb_code), .nb_psi_o(nb_psi)
  );

  always @(negedge clk) begin
    if (upd) upd_cnt++;
    if (rd)  rd_cnt++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic do_start();
    sdat = 1'b1; hw(); sclk = 1'b1; hw(); sdat = 1'b0; hw(); sclk = 1'b0; hw();
  endtask

  task automatic do_stop();
    sdat = 1'b0; hw(); sclk = 1'b1; hw(); sdat = 1'b1; hw();
  endtask

  task automatic send_bit(logic b);
    sdat = b; hw(); sclk = 1'b1; hw(); sclk = 1'b0;
  endtask

  task automatic send_body(logic [5:0] a, logic w, logic [7:0] d, int nd,
                           output logic ack_seen);
    for (int i = 5; i >= 0; i--) send_bit(a[i]);
    send_bit(w);
    sdat = 1'b1; hw();
    ack_seen = ack;
    sclk = 1'b1; hw(); sclk = 1'b0;
    for (int i = 0; i < nd; i++) send_bit(d[7-i]);
  endtask

  task automatic chk_rails(string req);
    chk(req, 32'(core_code), 32'(m_core));
    chk(req, 32'(core_psi), 32'(m_core_psi));
    chk(req, 32'(nb_code), 32'(m_nb));
    chk(req, 32'(nb_psi), 32'(m_nb_psi));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic a_seen;
    int u0, r0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 core code", 32'(core_code), 32'(BOOT));
    chk("R1 core psi", 32'(core_psi), 0);
    chk("R1 nb code", 32'(nb_code), 32'(BOOT));
    chk("R1 nb psi", 32'(nb_psi), 0);
    chk("R1 ack/rd/upd", {29'd0, ack, rd, upd}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [5:0] a;
      logic w, hit;
      logic [7:0] d;
      a = VEC[v][14:9]; w = VEC[v][8]; d = VEC[v][7:0];
      hit = (a == CORE_A) || (a == NB_A);
      u0 = upd_cnt; r0 = rd_cnt;
      do_start();
      send_body(a, w, d, 8, a_seen);
      do_stop();
      repeat (10) @(negedge clk);
      if (hit && !w) begin
        if (a == CORE_A) begin m_core = d[6:0]; m_core_psi = d[7]; end
        else begin m_nb = d[6:0]; m_nb_psi = d[7]; end
      end
      chk(hit ? "R4 ack" : "R5 no ack", 32'(a_seen), 32'(hit && !w));
      chk("R4 ack released", 32'(ack), 0);
      chk("R7 upd count", 32'(upd_cnt - u0), 32'(hit && !w));
      chk("R6 rd count", 32'(rd_cnt - r0), 32'(hit && w));
      chk_rails(hit ? "R3 rails" : "R5 rails");
    end

    // R8 abort mid-payload by a new start
    u0 = upd_cnt;
    do_start();
    send_body(CORE_A, 1'b0, 8'h7E, 4, a_seen);
    do_start();
    do_stop();
    repeat (10) @(negedge clk);
    chk("R8 abort ack", 32'(a_seen), 1);
    chk("R8 abort no upd", 32'(upd_cnt - u0), 0);
    chk_rails("R8 abort rails");
    do_start();
    send_body(CORE_A, 1'b0, 8'h7E, 8, a_seen);
    do_stop();
    repeat (10) @(negedge clk);
    m_core = 7'h7E; m_core_psi = 1'b0;
    chk("R8 recover upd", 32'(upd_cnt - u0), 1);
    chk_rails("R8 recover rails");

    // R2 bits without a start condition are ignored
    u0 = upd_cnt;
    sclk = 1'b0; hw();
    send_body(NB_A, 1'b0, 8'h81, 8, a_seen);
    do_stop();
    repeat (10) @(negedge clk);
    chk("R2 no start ack", 32'(a_seen), 0);
    chk("R2 no start upd", 32'(upd_cnt - u0), 0);
    chk_rails("R2 no start rails");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule